// File: doc/BRIEF.md
# Start-Stop and Synchronous Serial Transmitter

This block turns bytes written by a host into a serial bit stream, emitting exactly one bit for each pulse on a bit-rate strobe. A single holding register sits in front of a frame shift register, so the host can load the next byte while the current character is still being sent. The holding register's contents move into the shift register only at a character boundary.

In start-stop mode each character gets a zero start bit, 5 to 8 data bits sent least significant first, an optional odd or even parity bit and one or two stop bits at level one. A second write strobe marks a byte whose character drops one stop bit when two are configured, which gives rate adaptation. When the holding register is empty at a boundary, the line idles at one. In synchronous mode whole bytes go out with no framing. If no new byte is waiting, the last byte is sent again. Three fixed test patterns can also be selected. A ready flag shows that the holding register is empty. A sticky underflow flag records that a boundary found no data.

Top module: `frame_serializer`

## Requirements
- R1: During and just after synchronous reset, `ser_valid` is 0, `tx_ready` is 1 and `tx_underflow` is 0.
- R2: `ser_valid` is 1 in exactly the cycle after each cycle with `bit_tick` high, and 0 otherwise. `ser_out` changes only in those cycles.
- R3: With `cfg_fmt` not 11, a character is a 0 start bit, then N data bits least significant first, where N = 5 + `cfg_sel[2:1]` (00 gives 5, 11 gives 8), then `cfg_sel[0]`+1 stop bits at 1. Written bits above bit N-1 have no effect.
- R4: `cfg_fmt` 10 adds no parity. 01 adds an even-parity bit and 00 adds an odd-parity bit. The parity bit comes directly after the last data bit and covers only the N sent data bits.
- R5: A byte written with `wr_short` high is sent with one stop bit when `cfg_sel[0]` is 1. When `cfg_sel[0]` is 0 it is still sent with its single stop bit.
- R6: In start-stop mode, a boundary tick that finds the holding register empty sends a 1 and sets `tx_underflow`. The next tick is again a boundary, so a newly written byte starts on the next tick.
- R7: With `cfg_fmt` 11 and `cfg_sel[2]` 1, each buffered byte is sent as exactly 8 bits, least significant first, with no start, parity or stop bits. `wr_short` has no effect.
- R8: In that buffered synchronous mode, a boundary with an empty holding register sends the last transferred byte again and sets `tx_underflow`.
- R9: With `cfg_fmt` 11 and `cfg_sel[2]` 0, `cfg_sel` 011 sends continuous ones, 010 sends continuous zeros, and 000/001 send 1,0,1,0 starting with 1. The holding register is left untouched.
- R10: `tx_ready` is 1 exactly when the holding register is empty. A write clears it on the next cycle. A transfer at a boundary sets it, unless a write happens in the same cycle.
- R11: `tx_underflow` stays set until a write clears it. If an underflow and a write fall in the same cycle, the flag ends set.
- R12: `cfg_fmt` and `cfg_sel` take effect only at the next character boundary. A character already started finishes with the settings it began with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Framing: 11 synchronous, 10 no parity, 01 even parity, 00 odd parity |
| cfg_sel | input | 3 | Start-stop frame size, or synchronous data source |
| bit_tick | input | 1 | Bit-rate strobe, one bit per pulse |
| wr_en | input | 1 | Write a byte to the holding register |
| wr_short | input | 1 | With wr_en: send this byte with one stop bit fewer |
| wr_data | input | 8 | Byte to send |
| ser_out | output | 1 | Serial data bit |
| ser_valid | output | 1 | Pulses with each new serial bit |
| tx_ready | output | 1 | Holding register empty |
| tx_underflow | output | 1 | Sticky: a boundary found no data |

## Verification
A corrupted bit counter or a wrong shift register shows up on `ser_out` within the same character. It appears as a misplaced start bit, a wrong parity bit or a missing stop bit at the next tick that should carry it. A holding register that is lost or taken twice is visible at once on `tx_ready`. It is also visible at the next boundary, as a repeated byte, a skipped byte or a false underflow. Every tick's output is compared with a model computed from the framing rules, so an error is caught within one bit time.

// File: rtl/fst_pkg.sv
package fst_pkg;

    localparam int BYTE_W  = 8;
    localparam int FRAME_W = 12;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        FMT_ODD   = 2'b00,
        FMT_EVEN  = 2'b01,
        FMT_NOPAR = 2'b10,
        FMT_SYNC  = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [CNT_W-1:0]   len;
    } frame_t;

    // Start-stop character, LSB of bits leaves first.
    function automatic frame_t ss_frame(input logic [BYTE_W-1:0] d,
                                        input fmt_e f,
                                        input logic [2:0] sel,
                                        input logic shorten);
        frame_t r;
        int n;
        int p;
        int s;
        logic par;
        n = 5 + int'(sel[2:1]);
        p = (f == FMT_NOPAR) ? 0 : 1;
        s = sel[0] ? 2 : 1;
        if (shorten && s == 2) s = 1;
        r.bits    = '1;
        r.bits[0] = 1'b0;
        par = (f == FMT_ODD);
        for (int i = 0; i < BYTE_W; i++) begin
            if (i < n) begin
                r.bits[i+1] = d[i];
                par = par ^ d[i];
            end
        end
        if (p == 1) r.bits[n+1] = par;
        r.len = CNT_W'(1 + n + p + s);
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] sync_pattern(input logic [2:0] sel);
        case (sel)
            3'b011:  return '1;
            3'b010:  return '0;
            default: return 8'h55;
        endcase
    endfunction

endpackage

// File: rtl/fst_hold.sv
module fst_hold
    import fst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_short,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              take,
    output logic [BYTE_W-1:0] hold_data,
    output logic              hold_short,
    output logic              hold_full
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data  <= '0;
            hold_short <= 1'b0;
            hold_full  <= 1'b0;
        end else if (wr_en) begin
            hold_data  <= wr_data;
            hold_short <= wr_short;
            hold_full  <= 1'b1;
        end else if (take) begin
            hold_full  <= 1'b0;
        end
    end

endmodule

// File: rtl/fst_shift.sv
module fst_shift
    import fst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  fmt_e              fmt,
    input  logic [2:0]        sel,
    input  logic              hold_full,
    input  logic [BYTE_W-1:0] hold_data,
    input  logic              hold_short,
    output logic              take,
    output logic              udf_evt,
    output logic              ser_out,
    output logic              ser_valid
);

    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [BYTE_W-1:0]  last_q;
    logic               boundary;
    logic               pat_mode;
    logic               need_data;
    frame_t             nf;

    assign boundary  = (cnt_q == '0);
    assign pat_mode  = (fmt == FMT_SYNC) && !sel[2];
    assign need_data = !pat_mode;
    assign take      = bit_tick && boundary && need_data && hold_full;
    assign udf_evt   = bit_tick && boundary && need_data && !hold_full;

    always_comb begin
        nf.bits = '1;
        nf.len  = CNT_W'(BYTE_W);
        if (pat_mode) begin
            nf.bits[BYTE_W-1:0] = sync_pattern(sel);
        end else if (fmt == FMT_SYNC) begin
            nf.bits[BYTE_W-1:0] = hold_full ? hold_data : last_q;
        end else if (hold_full) begin
            nf = ss_frame(hold_data, fmt, sel, hold_short);
        end else begin
            nf.len = CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q      <= '1;
            cnt_q     <= '0;
            last_q    <= '0;
            ser_out   <= 1'b1;
            ser_valid <= 1'b0;
        end else begin
            ser_valid <= bit_tick;
            if (take) last_q <= hold_data;
            if (bit_tick) begin
                if (boundary) begin
                    ser_out <= nf.bits[0];
                    sh_q    <= nf.bits >> 1;
                    cnt_q   <= nf.len - 1'b1;
                end else begin
                    ser_out <= sh_q[0];
                    sh_q    <= sh_q >> 1;
                    cnt_q   <= cnt_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
    import fst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_fmt,
    input  logic [2:0] cfg_sel,
    input  logic       bit_tick,
    input  logic       wr_en,
    input  logic       wr_short,
    input  logic [7:0] wr_data,
    output logic       ser_out,
    output logic       ser_valid,
    output logic       tx_ready,
    output logic       tx_underflow
);

    logic              take;
    logic              udf_evt;
    logic [BYTE_W-1:0] hold_data;
    logic              hold_short;
    logic              hold_full;
    logic              udf_q;

    fst_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_short   (wr_short),
        .wr_data    (wr_data),
        .take       (take),
        .hold_data  (hold_data),
        .hold_short (hold_short),
        .hold_full  (hold_full)
    );

    fst_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .fmt        (fmt_e'(cfg_fmt)),
        .sel        (cfg_sel),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .hold_short (hold_short),
        .take       (take),
        .udf_evt    (udf_evt),
        .ser_out    (ser_out),
        .ser_valid  (ser_valid)
    );

    always_ff @(posedge clk) begin
        if (rst)          udf_q <= 1'b0;
        else if (udf_evt) udf_q <= 1'b1;
        else if (wr_en)   udf_q <= 1'b0;
    end

    assign tx_ready     = !hold_full;
    assign tx_underflow = udf_q;

endmodule

// File: rtl/fst_checker.sv
module fst_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_fmt,
    input logic [2:0] cfg_sel,
    input logic       bit_tick,
    input logic       wr_en,
    input logic       wr_short,
    input logic [7:0] wr_data,
    input logic       ser_out,
    input logic       ser_valid,
    input logic       tx_ready,
    input logic       tx_underflow
);

    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> ser_valid); // R2

    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> !ser_valid); // R2

    AST_OUT_STABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(ser_out)); // R2

    AST_READY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tx_ready); // R10

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !bit_tick) |=> $stable(tx_ready)); // R10

    AST_UDF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !bit_tick) |=> !tx_underflow); // R11

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && tx_underflow) |=> tx_underflow); // R11

    AST_UDF_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (!bit_tick && !tx_underflow) |=> !tx_underflow); // R6

endmodule

bind frame_serializer fst_checker chk_i (.*);

// File: tb/frame_serializer_tb.sv
module frame_serializer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_fmt = 2'b10;
    logic [2:0] cfg_sel = 3'b110;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_short = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ser_out;
    logic       ser_valid;
    logic       tx_ready;
    logic       tx_underflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    bit        m_full = 0;
    bit [7:0]  m_data = 0;
    bit        m_short = 0;
    bit [7:0]  m_last = 0;
    int        m_cnt = 0;
    bit [15:0] m_bits = '1;
    bit        m_out = 1;
    bit        m_udf = 0;
    string     m_tag = "R3";
    string     g_ctx = "";

    always #10 clk = ~clk;

    frame_serializer dut_i (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Bench-side frame builder: fills bits one at a time
    function automatic void build(input bit [1:0] f, input bit [2:0] s, input bit [7:0] d,
                                  input bit shrt, output bit [15:0] b, output int len);
        int n;
        int stops;
        bit ones;
        b = '1;
        len = 0;
        if (f == 2'b11) begin
            for (int i = 0; i < 8; i++) b[i] = d[i];
            len = 8;
            return;
        end
        n = 5 + s[2:1];
        stops = s[0] ? 2 : 1;
        if (shrt && stops == 2) stops = 1;
        b[len] = 0; len++;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            b[len] = d[i]; len++;
            ones ^= d[i];
        end
        if (f == 2'b01) begin b[len] = ones;  len++; end
        if (f == 2'b00) begin b[len] = !ones; len++; end
        for (int i = 0; i < stops; i++) begin b[len] = 1; len++; end
    endfunction

    task automatic step(input bit tk, input bit wr, input bit sh, input bit [7:0] d);
        bit [15:0] fb;
        int        fl;
        bit        load;
        bit        uset;
        bit [7:0]  old_data;
        load = 0;
        uset = 0;
        old_data = m_data;
        bit_tick = tk; wr_en = wr; wr_short = sh; wr_data = d;
        if (tk) begin
            if (m_cnt == 0) begin
                if (cfg_fmt == 2'b11 && !cfg_sel[2]) begin
                    fb = (cfg_sel == 3'b011) ? 16'hFFFF : (cfg_sel == 3'b010) ? 16'h0000 : 16'h0055;
                    fl = 8; m_tag = "R9";
                end else if (m_full) begin
                    load = 1;
                    build(cfg_fmt, cfg_sel, m_data, (cfg_fmt != 2'b11) && m_short, fb, fl);
                    if (cfg_fmt == 2'b11) m_tag = "R7";
                    else if (m_short) m_tag = "R5";
                    else if (cfg_fmt != 2'b10) m_tag = "R4";
                    else m_tag = "R3";
                end else begin
                    uset = 1;
                    if (cfg_fmt == 2'b11) begin
                        build(2'b11, cfg_sel, m_last, 0, fb, fl); m_tag = "R8";
                    end else begin
                        fb = '1; fl = 1; m_tag = "R6";
                    end
                end
                m_out  = fb[0];
                m_bits = fb >> 1;
                m_cnt  = fl - 1;
            end else begin
                m_out  = m_bits[0];
                m_bits = m_bits >> 1;
                m_cnt--;
            end
        end
        if (load) m_last = old_data;
        if (wr) begin m_full = 1; m_data = d; m_short = sh; end
        else if (load) m_full = 0;
        if (uset) m_udf = 1;
        else if (wr) m_udf = 0;
        @(negedge clk);
        bit_tick = 0; wr_en = 0; wr_short = 0;
        chk(ser_valid == tk, "R2 ser_valid", ser_valid, tk);
        if (tk) chk(ser_out == m_out, (g_ctx != "") ? g_ctx : m_tag, ser_out, m_out);
        chk(tx_ready == !m_full, "R10 tx_ready", tx_ready, !m_full);
        chk(tx_underflow == m_udf, "R11 tx_underflow", tx_underflow, m_udf);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 8'h00);
    endtask

    task automatic write(input bit [7:0] d, input bit sh);
        step(0, 1, sh, d);
    endtask

    task automatic set_cfg(input bit [1:0] f, input bit [2:0] s);
        cfg_fmt = f; cfg_sel = s;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd868);
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(ser_valid == 0, "R1 ser_valid", ser_valid, 0);
        chk(tx_ready == 1, "R1 tx_ready", tx_ready, 1);
        chk(tx_underflow == 0, "R1 tx_underflow", tx_underflow, 0);
        rst = 0;
        @(negedge clk);
        chk(tx_ready == 1 && tx_underflow == 0, "R1 after release", {tx_ready, tx_underflow}, 2);

        // R3: 8 data, no parity, 1 stop
        set_cfg(2'b10, 3'b110); write(8'hA5, 0); ticks(10);
        // R6: idle ones after the character
        ticks(3);
        // R4: even parity, 7 data, 2 stops
        set_cfg(2'b01, 3'b101); write(8'hFF, 0); ticks(11);
        // R4: odd parity, 5 data, upper bits ignored (R3)
        set_cfg(2'b00, 3'b000); write(8'hE3, 0); ticks(8);
        // R5: short write with two stops, then with one stop
        set_cfg(2'b10, 3'b111); write(8'h3C, 1); ticks(11);
        set_cfg(2'b10, 3'b110); write(8'h81, 1); ticks(11);
        // R10: back-to-back characters, second write during the first
        set_cfg(2'b01, 3'b011); write(8'h12, 0); step(1, 0, 0, 0);
        write(8'h34, 0); ticks(20);
        // R10/R11: write in the same cycle as a boundary
        set_cfg(2'b10, 3'b010); step(1, 1, 0, 8'h2B); step(1, 1, 0, 8'h17); ticks(20);
        // R7: synchronous bytes, short strobe ignored
        set_cfg(2'b11, 3'b100); write(8'h3C, 1); ticks(1); write(8'hC9, 0); ticks(8);
        // R8: repeat last byte on underflow
        ticks(16);
        // R9: patterns
        write(8'h77, 0);
        set_cfg(2'b11, 3'b011); ticks(16);
        set_cfg(2'b11, 3'b010); ticks(8);
        set_cfg(2'b11, 3'b000); ticks(8);
        set_cfg(2'b11, 3'b001); ticks(8);
        // R12: config change mid character
        set_cfg(2'b10, 3'b110); ticks(1); write(8'h5A, 0);
        g_ctx = "R12";
        ticks(3); set_cfg(2'b11, 3'b010); ticks(8); set_cfg(2'b00, 3'b001); ticks(6);
        g_ctx = "";
        ticks(12);

        // Constrained random mix
        for (int i = 0; i < 6000; i++) begin
            bit tk;
            bit wr;
            if (($urandom % 150) == 0) set_cfg(2'($urandom), 3'($urandom));
            tk = ($urandom % 3) != 0;
            wr = ($urandom % 7) == 0;
            step(tk, wr, 1'($urandom), 8'($urandom));
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule